// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block

This block gathers single-cycle event pulses from a display output wrapper and turns them into one level-sensitive interrupt line. Each event source owns one bit. A pulse latches its bit in a raw status register, which holds it until software acknowledges it. An enable mask selects which latched events may reach the interrupt line. The masked status view is the raw status ANDed with that mask.

Software uses a simple register bus with word addresses. The enable mask has no plain write address. It changes only through a set address, where each 1 turns a bit on, and a clear address, where each 1 turns a bit off. Reading either address returns the mask. Software acknowledges events by writing ones to the masked-status address. A read issued in the cycle after such a write returns the updated status, so the read can be used to flush a posted write. A wake-enable word is stored and read back. It has no effect on the interrupt line.

Top module: `irq_wrapper_regs`

## Requirements
- R1: While and after reset, every status bit, enable bit and wake bit is zero, `irq_out` is low, and a read of any address returns 0.
- R2: A 1 on `evt_pulse[i]` sampled at a clock edge sets raw status bit i at that edge. The bit stays set until cleared. It shows at the raw-status address (word 0) whether or not bit i is enabled.
- R3: A write to the enable-set address (word 2) turns on exactly the enable bits written as 1 and leaves the other enable bits unchanged.
- R4: A write to the enable-clear address (word 3) turns off exactly the enable bits written as 1 and leaves the other enable bits unchanged.
- R5: A read of either word 2 or word 3 returns the current enable mask.
- R6: A read of the masked-status address (word 1) returns raw status AND enable.
- R7: A write to word 1 clears the status bits written as 1 and leaves the others unchanged. A write to word 0 has no effect.
- R8: If an event pulse and a clearing write hit the same bit at the same edge, the bit ends up set.
- R9: `bus_rdata` and `bus_rvalid` are registered and appear at the edge that samples `bus_rd`. A read issued in the cycle after a write returns the value as that write left it.
- R10: `irq_out` equals the OR of the masked status bits, registered, so it follows a state change by one clock edge.
- R11: The wake-enable word (word 4) stores and returns NUM_SRC bits, and its value never changes `irq_out`.
- R12: Data bits at and above NUM_SRC read as 0 and are ignored on writes. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | High for the cycle in which bus_rdata holds a fresh read |
| evt_pulse | input | NUM_SRC | One single-cycle pulse per event source |
| irq_out | output | 1 | Interrupt request line, active high |

## Verification
The hardest case to produce from the ports is a new event and a software acknowledge landing on the same bit at the same edge. The bench drives the event pulse and the write to word 1 from the same falling edge, so both are sampled together. It then reads raw status back to confirm that the bit survived. The interrupt line's one-edge lag is checked the same way: the bench samples `irq_out` at the falling edge just after a change, where the old value should still show, and again one edge later.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam int unsigned ADR_RAW  = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_ESET = 2;
  localparam int unsigned ADR_ECLR = 3;
  localparam int unsigned ADR_WAKE = 4;

  typedef struct packed {
    logic raw;
    logic stat;
    logic eset;
    logic eclr;
    logic wake;
  } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel      = '0;
    sel.raw  = (addr == ADDR_W'(ADR_RAW));
    sel.stat = (addr == ADDR_W'(ADR_STAT));
    sel.eset = (addr == ADDR_W'(ADR_ESET));
    sel.eclr = (addr == ADDR_W'(ADR_ECLR));
    sel.wake = (addr == ADDR_W'(ADR_WAKE));
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] stat_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr_i;
    assign clr_i = ack_we & ack_mask[i];
    always_ff @(posedge clk) begin
      if (rst)
        stat_q[i] <= 1'b0;
      else if (evt[i])
        stat_q[i] <= 1'b1;
      else if (clr_i)
        stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic               wake_we,
  input  logic [NUM_SRC-1:0] wmask,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] wake_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (set_we) begin
      en_q <= en_q | wmask;
    end else if (clr_we) begin
      en_q <= en_q & ~wmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      wake_q <= '0;
    else if (wake_we)
      wake_q <= wmask;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  reg_sel_t           sel,
  input  logic [NUM_SRC-1:0] stat_q,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] wake_q,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid
);
  logic [NUM_SRC-1:0] pick;

  always_comb begin
    pick = '0;
    if (sel.raw)                pick = stat_q;
    if (sel.stat)               pick = stat_q & en_q;
    if (sel.eset || sel.eclr)   pick = en_q;
    if (sel.wake)               pick = wake_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd)
        rdata <= DATA_W'(pick);
    end
  end
endmodule

// File: rtl/irq_wrapper_regs.sv
module irq_wrapper_regs
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic               irq_out
);
  reg_sel_t           sel;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] wake_q;

  assign wmask = bus_wdata[NUM_SRC-1:0];

  if (DATA_W > NUM_SRC) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
  end

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_pulse),
    .ack_we   (bus_wr & sel.stat),
    .ack_mask (wmask),
    .stat_q   (stat_q)
  );

  irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_en (
    .clk     (clk),
    .rst     (rst),
    .set_we  (bus_wr & sel.eset),
    .clr_we  (bus_wr & sel.eclr),
    .wake_we (bus_wr & sel.wake),
    .wmask   (wmask),
    .en_q    (en_q),
    .wake_q  (wake_q)
  );

  irq_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .sel    (sel),
    .stat_q (stat_q),
    .en_q   (en_q),
    .wake_q (wake_q),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq_out <= 1'b0;
    else
      irq_out <= |(stat_q & en_q);
  end
endmodule

// File: rtl/irq_regs_checker.sv
module irq_regs_checker
  import irq_regs_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_rvalid,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               irq_out
);
  logic [NUM_SRC-1:0] m;
  assign m = bus_wdata[NUM_SRC-1:0];

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_pulse)) == '0)); // R2
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_ESET)) |=> (en_q == ($past(en_q) | $past(m)))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_ECLR)) |=> (en_q == ($past(en_q) & ~$past(m)))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_STAT) && evt_pulse == '0) |=> ((stat_q & $past(m)) == '0)); // R7
  AST_EVT_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(ADR_STAT) && (evt_pulse & m) != '0)
      |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse))); // R8
  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_rvalid == $past(bus_rd))); // R9
  AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(stat_q & en_q)))); // R10
endmodule

bind irq_wrapper_regs irq_regs_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .evt_pulse  (evt_pulse),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .irq_out    (irq_out)
);

// File: tb/tb_irq_wrapper_regs.sv
module tb_irq_wrapper_regs;
  localparam int NUM_SRC = 8;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  adr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{OP_EV, 4'h0, 32'h05, 32'h00, 4'd2},          // R2 events 0 and 2
    '{OP_RD, 4'h0, 32'h00, 32'h05, 4'd2},          // R2 raw shows disabled bits
    '{OP_RD, 4'h1, 32'h00, 32'h00, 4'd6},          // R6 nothing enabled
    '{OP_WR, 4'h2, 32'h0C, 32'h00, 4'd3},
    '{OP_RD, 4'h2, 32'h00, 32'h0C, 4'd5},          // R5 R3
    '{OP_WR, 4'h2, 32'h01, 32'h00, 4'd3},
    '{OP_RD, 4'h3, 32'h00, 32'h0D, 4'd3},          // R3 others kept, R5 via clear addr
    '{OP_RD, 4'h1, 32'h00, 32'h05, 4'd6},          // R6
    '{OP_WR, 4'h3, 32'h04, 32'h00, 4'd4},
    '{OP_RD, 4'h2, 32'h00, 32'h09, 4'd4},          // R4
    '{OP_RD, 4'h1, 32'h00, 32'h01, 4'd6},          // R6
    '{OP_WR, 4'h1, 32'h01, 32'h00, 4'd7},
    '{OP_RD, 4'h0, 32'h00, 32'h04, 4'd7},          // R7 ack clears bit 0 only
    '{OP_WR, 4'h0, 32'hFF, 32'h00, 4'd7},
    '{OP_RD, 4'h0, 32'h00, 32'h04, 4'd7},          // R7 raw address write ignored
    '{OP_WR, 4'h4, 32'hA5, 32'h00, 4'd11},
    '{OP_RD, 4'h4, 32'h00, 32'hA5, 4'd11},         // R11
    '{OP_WR, 4'h7, 32'hFF, 32'h00, 4'd12},
    '{OP_RD, 4'h7, 32'h00, 32'h00, 4'd12},         // R12 unmapped
    '{OP_WR, 4'h2, 32'hFFFF_FFFF, 32'h00, 4'd12},
    '{OP_RD, 4'h2, 32'h00, 32'hFF, 4'd12}          // R12 high bits read zero
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic [DATA_W-1:0]  bus_wdata = '0;
  logic [DATA_W-1:0]  bus_rdata;
  logic               bus_rvalid;
  logic [NUM_SRC-1:0] evt_pulse = '0;
  logic               irq_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_wrapper_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_pulse(evt_pulse), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
    check(tag, bus_rdata, exp);
  endtask

  task automatic do_ev(input logic [NUM_SRC-1:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq during reset", {31'd0, irq_out}, 32'd0);
    rst = 1'b0;
    do_rd(4'h0, 32'h0, "R1 raw after reset");
    do_rd(4'h2, 32'h0, "R1 enable after reset");
    do_rd(4'h4, 32'h0, "R1 wake after reset");

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_WR: do_wr(VECS[k].adr, VECS[k].data);
        OP_EV: do_ev(VECS[k].data[NUM_SRC-1:0]);
        default: do_rd(VECS[k].adr, VECS[k].exp, $sformatf("R%0d step %0d", VECS[k].req, k));
      endcase
    end

    // enable = 0xFF, raw = 0x04: line is up
    check("R10 irq high with enabled bit", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h1; bus_wdata = 32'h04;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    check("R10 irq lags ack by one edge", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R10 irq drops after ack", {31'd0, irq_out}, 32'd0);

    // event and acknowledge on the same bit at the same edge
    @(negedge clk);
    evt_pulse = 8'h02; bus_wr = 1'b1; bus_addr = 4'h1; bus_wdata = 32'h02;
    @(negedge clk);
    evt_pulse = '0; bus_wr = 1'b0; bus_wdata = '0;
    check("R10 irq still low one edge after event", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R10 irq rises after event", {31'd0, irq_out}, 32'd1);
    do_rd(4'h0, 32'h02, "R8 event wins over clear");

    // flush: read right after acknowledge
    do_wr(4'h1, 32'h02);
    do_rd(4'h1, 32'h00, "R9 read after write sees clear");
    do_wr(4'h2, 32'h10);
    do_rd(4'h3, 32'hFF, "R9 read after set");

    // wake does not drive the line
    do_wr(4'h3, 32'hFF);
    do_wr(4'h4, 32'hFF);
    do_ev(8'h08);
    @(negedge clk);
    check("R11 wake bits leave irq low", {31'd0, irq_out}, 32'd0);
    do_rd(4'h0, 32'h08, "R2 raw latched while masked");

    // reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_rd(4'h0, 32'h0, "R1 raw after second reset");
    do_rd(4'h4, 32'h0, "R1 wake after second reset");
    check("R1 irq after second reset", {31'd0, irq_out}, 32'd0);

    finish_run();
  end
endmodule